// File: doc/BRIEF.md
# Three-Wire Serial Control Register for a Dual Synthesiser

This block takes control words for two synthesiser loops over a write-only serial bus with three lines: a serial clock, serial data and an enable. The clock and data lines may be shared with other devices. The enable line selects this device alone. The bus lines are brought into the system clock domain through synchronisers. A data bit is taken on each rising bus-clock edge while enable is high, most significant bit first.

When enable falls, the last bit received is read as an address. A 0 selects the loop-1 register set and a 1 selects the loop-2 register set. Words differ in length, so every field is decoded right-aligned from that last bit. Each loop's divider word, reference-ratio code and charge-pump code are presented as outputs. The test-mode bits and the two general-purpose port bits are also presented. Port drivers stay high-impedance, signalled by a low enable output, until the first valid loop-1 word has been stored.

Top module: `three_wire_ctrl`

## Requirements
- R1: After reset, every field output is 0 and `port_oe_o` is 0.
- R2: Bits are shifted in only on a rising `sclk_i` while `sen_i` is high. Bus-clock edges while `sen_i` is low change no output.
- R3: Register update happens only on a falling `sen_i`. Received bit 0 is the address: 0 writes the loop-1 set and 1 writes the loop-2 set.
- R4: A loop-1 word is 23 bits, with received bit k counted from the last bit (k = 0).
  - Bits 15..1 are the divider word `l1_freq_o`.
  - Bits 18..16 are `l1_ref_o`.
  - Bits 20..19 are `l1_cp_o`.
  - Bit 21 is port bit `port_o[0]`.
  - Bit 22 is port bit `port_o[1]`.
- R5: A full loop-2 word is 24 bits, with received bit k counted from the last bit (k = 0).
  - Bits 16..1 are `l2_freq_o`.
  - Bits 19..17 are `l2_ref_o`.
  - Bit 20 is `l2_cp_o`.
  - Bits 23, 22 and 21 are test bits 2, 1 and 0, shown on `test_o[2:0]`.
- R6: A loop-2 word of 22 or 23 bits is accepted when its test bit 0 (bit 21) is 0. Whenever test bit 0 is 0, `test_o` reads 3'b000, whatever the higher test bits held.
- R7: A transfer is discarded and no output changes when it is shorter than 23 bits with address 0, or shorter than 22 bits with address 1.
- R8: A loop-2 word with test bit 0 set but fewer than 24 bits is discarded.
- R9: In a transfer longer than 24 bits only the last 24 bits count; earlier bits are ignored.
- R10: `port_oe_o` stays 0 until the first valid loop-1 word is stored, then stays 1. A loop-2 word does not raise it.
- R11: Writing one loop's register set leaves the other set unchanged.
- R12: With the default two synchroniser stages, new values appear at the outputs on the third rising `clk_i` edge after `sen_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, sampling the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bus clock |
| sdata_i | input | 1 | Serial bus data, MSB first |
| sen_i | input | 1 | Device enable, high during a transfer |
| l1_freq_o | output | 15 | Loop-1 divider word |
| l1_ref_o | output | 3 | Loop-1 reference-ratio code |
| l1_cp_o | output | 2 | Loop-1 charge-pump current code |
| l2_freq_o | output | 16 | Loop-2 divider word |
| l2_ref_o | output | 3 | Loop-2 reference-ratio code |
| l2_cp_o | output | 1 | Loop-2 charge-pump current code |
| test_o | output | 3 | Test-mode bits 2..0 |
| port_o | output | 2 | General-purpose port bits |
| port_oe_o | output | 1 | Port driver enable (0 = high-impedance) |

## Verification
Every register update is due on the third system-clock edge after enable falls: two edges pass through the synchroniser and the third is the commit edge. Shifted bits reach no output until that commit. The bench model therefore applies its expected values right after that third edge, and it compares every output at each falling clock edge. An output that moves one cycle early or late is caught. After each transfer the bench also makes a check tagged with the requirement under test, at a time when both the model and the design have settled.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned FREQ1_W = 15;
  localparam int unsigned FREQ2_W = 16;
  localparam int unsigned REF_W   = 3;
  localparam int unsigned CP1_W   = 2;
  localparam int unsigned TEST_W  = 3;
  localparam int unsigned PORT_W  = 2;
  localparam int unsigned L1_BITS = 1 + FREQ1_W + REF_W + CP1_W + PORT_W;  // 23
  localparam int unsigned L2_FULL = 1 + FREQ2_W + REF_W + 1 + TEST_W;      // 24
  localparam int unsigned L2_MIN  = L2_FULL - (TEST_W - 1);                // 22
  localparam int unsigned SR_W    = (L1_BITS > L2_FULL) ? L1_BITS : L2_FULL;
  localparam int unsigned CNT_W   = $clog2(SR_W + 1);

  typedef struct packed {
    logic [PORT_W-1:0]  port;
    logic [CP1_W-1:0]   cp;
    logic [REF_W-1:0]   ref_code;
    logic [FREQ1_W-1:0] freq;
  } loop1_t;

  typedef struct packed {
    logic [TEST_W-1:0]  tmode;
    logic               cp;
    logic [REF_W-1:0]   ref_code;
    logic [FREQ2_W-1:0] freq;
  } loop2_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
module tw_shift
  import tw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             sdata_s_i,
  input  logic             sen_s_i,
  output logic [SR_W-1:0]  word_o,
  output logic [CNT_W-1:0] count_o,
  output logic             commit_o
);
  logic             sclk_q, sen_q;
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic             sclk_rise, sen_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign sen_rise  = sen_s_i & ~sen_q;
  assign cnt_base  = sen_rise ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sen_q  <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      sen_q  <= sen_s_i;
      if (sen_s_i && sclk_rise) begin
        sr_q  <= {sr_q[SR_W-2:0], sdata_s_i};
        cnt_q <= (cnt_base == CNT_W'(SR_W)) ? cnt_base : cnt_base + 1'b1;
      end else begin
        cnt_q <= cnt_base;
      end
    end
  end

  assign commit_o = sen_q & ~sen_s_i;
  assign word_o   = sr_q;
  assign count_o  = cnt_q;

  // R2
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_s_i |=> $stable(sr_q));

  // R9
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SR_W));
endmodule

// File: rtl/tw_regs.sv
module tw_regs
  import tw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [SR_W-1:0]  word_i,
  input  logic [CNT_W-1:0] count_i,
  output loop1_t           l1_o,
  output loop2_t           l2_o,
  output logic             port_oe_o
);
  loop1_t l1_q, l1_d;
  loop2_t l2_q, l2_d;
  logic   oe_q;
  logic   addr, t0, l1_ok, l2_ok;

  assign addr  = word_i[0];
  assign t0    = word_i[L2_MIN-1];
  assign l1_ok = commit_i && !addr && (count_i >= CNT_W'(L1_BITS));
  assign l2_ok = commit_i && addr &&
                 ((count_i >= CNT_W'(L2_FULL)) || ((count_i >= CNT_W'(L2_MIN)) && !t0));

  assign l1_d = word_i[L1_BITS-1:1];

  always_comb begin
    l2_d = word_i[L2_FULL-1:1];
    if (!t0) l2_d.tmode = '0;  // higher test bits are don't-care
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_q <= '0;
      l2_q <= '0;
      oe_q <= 1'b0;
    end else begin
      if (l1_ok) begin
        l1_q <= l1_d;
        oe_q <= 1'b1;
      end
      if (l2_ok) l2_q <= l2_d;
    end
  end

  assign l1_o      = l1_q;
  assign l2_o      = l2_q;
  assign port_oe_o = oe_q;

  // R10
  oe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |=> oe_q);

  // R6
  tmode_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l2_q.tmode[0] |-> (l2_q.tmode[TEST_W-1:1] == '0));

  // R11
  l1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && !word_i[0]) |=> $stable(l1_q));

  // R7
  short_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && count_i < CNT_W'(L2_MIN)) |=> ($stable(l1_q) && $stable(l2_q)));
endmodule

// File: rtl/three_wire_ctrl.sv
module three_wire_ctrl
  import tw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               sen_i,
  output logic [FREQ1_W-1:0] l1_freq_o,
  output logic [REF_W-1:0]   l1_ref_o,
  output logic [CP1_W-1:0]   l1_cp_o,
  output logic [FREQ2_W-1:0] l2_freq_o,
  output logic [REF_W-1:0]   l2_ref_o,
  output logic               l2_cp_o,
  output logic [TEST_W-1:0]  test_o,
  output logic [PORT_W-1:0]  port_o,
  output logic               port_oe_o
);
  logic             sclk_s, sdata_s, sen_s, commit;
  logic [SR_W-1:0]  word;
  logic [CNT_W-1:0] count;
  loop1_t           l1;
  loop2_t           l2;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (.clk_i, .rst_ni, .d_i(sclk_i),  .q_o(sclk_s));
  tw_sync #(.STAGES(SYNC_STAGES)) u_sync_data (.clk_i, .rst_ni, .d_i(sdata_i), .q_o(sdata_s));
  tw_sync #(.STAGES(SYNC_STAGES)) u_sync_sen  (.clk_i, .rst_ni, .d_i(sen_i),   .q_o(sen_s));

  tw_shift u_shift (
    .clk_i, .rst_ni,
    .sclk_s_i(sclk_s), .sdata_s_i(sdata_s), .sen_s_i(sen_s),
    .word_o(word), .count_o(count), .commit_o(commit)
  );

  tw_regs u_regs (
    .clk_i, .rst_ni,
    .commit_i(commit), .word_i(word), .count_i(count),
    .l1_o(l1), .l2_o(l2), .port_oe_o(port_oe_o)
  );

  assign l1_freq_o = l1.freq;
  assign l1_ref_o  = l1.ref_code;
  assign l1_cp_o   = l1.cp;
  assign port_o    = l1.port;
  assign l2_freq_o = l2.freq;
  assign l2_ref_o  = l2.ref_code;
  assign l2_cp_o   = l2.cp;
  assign test_o    = l2.tmode;
endmodule

// File: tb/sim_three_wire_ctrl.sv
module sim_three_wire_ctrl;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sen = 1'b0;
  logic [14:0] l1_freq; logic [2:0] l1_ref; logic [1:0] l1_cp;
  logic [15:0] l2_freq; logic [2:0] l2_ref; logic l2_cp;
  logic [2:0] test; logic [1:0] port; logic port_oe;

  always #10 clk = ~clk;

  three_wire_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sen_i(sen),
    .l1_freq_o(l1_freq), .l1_ref_o(l1_ref), .l1_cp_o(l1_cp),
    .l2_freq_o(l2_freq), .l2_ref_o(l2_ref), .l2_cp_o(l2_cp),
    .test_o(test), .port_o(port), .port_oe_o(port_oe)
  );

  // reference model state
  logic [14:0] e_l1_freq = '0; logic [2:0] e_l1_ref = '0; logic [1:0] e_l1_cp = '0;
  logic [15:0] e_l2_freq = '0; logic [2:0] e_l2_ref = '0; logic e_l2_cp = 1'b0;
  logic [2:0] e_test = '0; logic [1:0] e_port = '0; logic e_oe = 1'b0;
  bit q[$];
  int checks = 0, errors = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "l1_freq", l1_freq, e_l1_freq);
    chk(tag, "l1_ref", l1_ref, e_l1_ref);
    chk(tag, "l1_cp", l1_cp, e_l1_cp);
    chk(tag, "port", port, e_port);
    chk(tag, "port_oe", port_oe, e_oe);
    chk(tag, "l2_freq", l2_freq, e_l2_freq);
    chk(tag, "l2_ref", l2_ref, e_l2_ref);
    chk(tag, "l2_cp", l2_cp, e_l2_cp);
    chk(tag, "test", test, e_test);
  endtask

  // per-clock comparison; timing tag R12
  always @(negedge clk) if (cmp_on) compare("R12");

  // model applies a finished transfer following the requirements
  task automatic model_commit();
    int n = q.size();
    int a, t0;
    int w[32];
    for (int k = 0; k < 32; k++) w[k] = (k < n) ? int'(q[n-1-k]) : 0;
    if (n == 0) return;
    a = w[0];
    t0 = w[21];
    if (a == 0 && n >= 23) begin
      e_l1_freq = '0;
      for (int k = 0; k < 15; k++) e_l1_freq[k] = w[1+k][0];
      e_l1_ref = {w[18][0], w[17][0], w[16][0]};
      e_l1_cp  = {w[20][0], w[19][0]};
      e_port   = {w[22][0], w[21][0]};
      e_oe     = 1'b1;
    end else if (a == 1 && (n >= 24 || (n >= 22 && t0 == 0))) begin
      for (int k = 0; k < 16; k++) e_l2_freq[k] = w[1+k][0];
      e_l2_ref = {w[19][0], w[18][0], w[17][0]};
      e_l2_cp  = w[20][0];
      e_test   = (t0 == 1) ? {w[23][0], w[22][0], 1'b1} : 3'b000;
    end
  endtask

  task automatic push_bits(logic [31:0] v, int nb);
    for (int i = nb - 1; i >= 0; i--) q.push_back(v[i]);
  endtask

  task automatic transfer();
    @(negedge clk) sen = 1'b1;
    repeat (3) @(negedge clk);
    foreach (q[i]) begin
      sdata = q[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
    sen = 1'b0;
    repeat (LAT) @(posedge clk);
    model_commit();
    q.delete();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    compare("R1");
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (2) @(negedge clk);

    // loop-2 full word before any loop-1 word: T2=0 T1=1 T0=1 CD=1 RD=110
    push_bits({3'b011, 1'b1, 3'b110, 16'hC3A5, 1'b1}, 24);
    transfer();
    compare("R5");
    chk("R10", "oe after loop-2 only", port_oe, 0);

    // loop-1 word: P1P0=10 CU=01 RU=101
    push_bits({2'b10, 2'b01, 3'b101, 15'h2A5B, 1'b0}, 23);
    transfer();
    compare("R4");
    chk("R3", "l1_freq", l1_freq, 15'h2A5B);
    chk("R10", "oe after loop-1", port_oe, 1);
    chk("R11", "l2_freq kept", l2_freq, 16'hC3A5);

    // short loop-2 word, T0=0
    push_bits({1'b0, 1'b0, 3'b011, 16'h1234, 1'b1}, 22);
    transfer();
    compare("R6");
    chk("R6", "test cleared", test, 0);
    chk("R11", "l1_ref kept", l1_ref, 3'b101);

    // loop-1 word too short: discarded
    push_bits({4'h0, 15'h7FFF, 1'b0}, 20);
    transfer();
    compare("R7");
    chk("R7", "l1_freq kept", l1_freq, 15'h2A5B);

    // loop-2 word with T0=1 but only 22 bits: discarded
    push_bits({1'b1, 1'b1, 3'b111, 16'hFFFF, 1'b1}, 22);
    transfer();
    compare("R8");
    chk("R8", "l2_freq kept", l2_freq, 16'h1234);

    // long loop-1 word with 7 leading junk bits
    push_bits({7'h55, 2'b01, 2'b11, 3'b010, 15'h0F0F, 1'b0}, 30);
    transfer();
    compare("R9");
    chk("R9", "port", port, 2'b01);

    // bus-clock activity with enable low: ignored
    for (int i = 0; i < 8; i++) begin
      sdata = i[0];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    compare("R2");
    chk("R2", "l1_cp kept", l1_cp, 2'b11);

    // 23-bit loop-2 word, T1=1 T0=0: accepted, test still 000
    push_bits({1'b1, 1'b0, 1'b1, 3'b001, 16'hBEEF, 1'b1}, 23);
    transfer();
    compare("R6");
    chk("R3", "l2_freq", l2_freq, 16'hBEEF);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule